// File: doc/BRIEF.md
# Storage Command Decoder Queue

This block sits between a host-protocol frame parser and the flash translation stage of a storage controller. Each host command reaches it as a fixed frame of three 32-bit words on a valid/ready stream. The block pulls the command kind, the force-unit-access bit, the starting logical block address and the sector count out of the frame. It compares the start address with the point where the previous accepted command ended, which sets a continuity flag. It then writes one compact descriptor into a 32-entry first-in first-out command queue.

The translation stage reads the queue through a show-ahead pop interface. The head descriptor is on the outputs whenever `q_valid` is high, and a one-cycle `q_pop` pulse removes it. When the queue is full the frame input stops accepting words, so a command is never lost. Executing commands, mapping addresses and moving data are outside this block.

Top module: `stor_cmd_decq`

## Requirements
- R1: A frame is three words taken in order. Word 0 holds the opcode in bits [7:0], the access flag in bit 8 and the sector count in bits [31:16]. Word 1 holds LBA bits [31:0]. Word 2 bits [15:0] hold LBA bits [47:32]. Opcode 0x20 gives type code 2'b01 (read) and opcode 0x30 gives type code 2'b10 (write).
- R2: The descriptor carries the 48-bit start LBA unchanged. Its 17-bit length equals the sector count, except that a count of zero gives a length of 65536.
- R3: The descriptor's force-unit-access output equals bit 8 of word 0.
- R4: For a read or a write, the continuity flag is 1 exactly when the start LBA equals the previous read or write's start LBA plus its length, taken modulo 2^48.
- R5: The first command accepted after reset always has a continuity flag of 0.
- R6: Any other opcode gives type code 2'b11 with a continuity flag of 0, and it leaves the end-address tracker unchanged.
- R7: Descriptors leave the queue in arrival order. The head stays stable while `q_valid` is high and `q_pop` is low, and a `q_pop` pulse removes exactly one entry.
- R8: The queue holds 32 descriptors. `frm_ready` is low while it is full, and every frame offered is eventually queued with no loss.
- R9: A `q_pop` while the queue is empty has no effect.
- R10: Reset empties the queue, raises `frm_ready` and discards a partly received frame, so the next word is taken as word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame word present |
| frm_ready | output | 1 | Block accepts the frame word |
| frm_data | input | 32 | Frame word |
| q_valid | output | 1 | Queue head holds a descriptor |
| q_pop | input | 1 | Remove the head descriptor |
| q_type | output | 2 | Head type code: 01 read, 10 write, 11 unsupported |
| q_fua | output | 1 | Head force-unit-access flag |
| q_cont | output | 1 | Head continuity flag |
| q_lba | output | 48 | Head start LBA |
| q_len | output | 17 | Head length in sectors (1 to 65536) |

## Verification
The bench sends a zero sector count, which a careless design would report as a length of 0 and use to compute a wrong continuation point. It sends a range that ends at the top of the 48-bit address space, so the next command at LBA 0 must be marked continuous; a tracker that failed to wrap would call it random. It places an unsupported opcode between two commands whose addresses follow on, so a design that let the bad command update the tracker would clear the flag on the next good one. The bench also fills the queue, holds a 33rd frame against backpressure, pops empty queues and resets in the middle of a frame. A drop, a duplicate or a misaligned frame in those cases shows up as a wrong address at the head.

// File: rtl/stor_cmd_pkg.sv
package stor_cmd_pkg;

  localparam int WORD_W   = 32;
  localparam int LBA_W    = 48;
  localparam int CNT_W    = 16;
  localparam int LEN_W    = CNT_W + 1;
  localparam int FRM_WORDS = 3;
  localparam int IDX_W    = $clog2(FRM_WORDS);

  localparam logic [7:0] OP_READ  = 8'h20;
  localparam logic [7:0] OP_WRITE = 8'h30;

  typedef enum logic [1:0] {
    TYP_NONE  = 2'b00,
    TYP_READ  = 2'b01,
    TYP_WRITE = 2'b10,
    TYP_BAD   = 2'b11
  } cmd_type_e;

  typedef struct packed {
    cmd_type_e         kind;
    logic              fua;
    logic              cont;
    logic [LBA_W-1:0]  lba;
    logic [LEN_W-1:0]  len;
  } cmd_desc_t;

  // Sector count field to span: zero encodes the largest transfer.
  function automatic logic [LEN_W-1:0] span_of(input logic [CNT_W-1:0] cnt);
    if (cnt == '0) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, cnt};
  endfunction

  // First LBA past a range, wrapping at the top of the address space.
  function automatic logic [LBA_W-1:0] end_of(input logic [LBA_W-1:0] lba,
                                              input logic [LEN_W-1:0] len);
    return lba + LBA_W'(len);
  endfunction

  function automatic cmd_type_e kind_of(input logic [7:0] op);
    case (op)
      OP_READ:  return TYP_READ;
      OP_WRITE: return TYP_WRITE;
      default:  return TYP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/stor_cmd_frame_asm.sv
module stor_cmd_frame_asm
  import stor_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [WORD_W-1:0]   data,
  output logic                frame_done,
  output logic [7:0]          op,
  output logic                fua,
  output logic [CNT_W-1:0]    cnt,
  output logic [LBA_W-1:0]    lba
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRM_WORDS - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        op_q;
  logic              fua_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       lba_lo_q;
  logic              rsvd_unused;

  assign rsvd_unused = ^{data[15:9]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      op_q     <= '0;
      fua_q    <= 1'b0;
      cnt_q    <= '0;
      lba_lo_q <= '0;
    end else if (accept) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      if (idx_q == '0) begin
        op_q  <= data[7:0];
        fua_q <= data[8];
        cnt_q <= data[31:16];
      end
      if (idx_q == IDX_W'(1)) lba_lo_q <= data[31:0];
    end
  end

  assign frame_done = accept && (idx_q == LAST_IDX);
  assign op         = op_q;
  assign fua        = fua_q;
  assign cnt        = cnt_q;
  assign lba        = {data[LBA_W-33:0], lba_lo_q};

endmodule

// File: rtl/stor_cmd_classify.sv
module stor_cmd_classify
  import stor_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [7:0]         op,
  input  logic               fua,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [LBA_W-1:0]   lba,
  output cmd_desc_t          desc,
  output logic               track_upd
);

  logic [LBA_W-1:0] prev_end_q;
  logic             have_prev_q;
  cmd_type_e        kind;
  logic [LEN_W-1:0] len;
  logic             good;

  always_comb begin
    kind = kind_of(op);
    len  = span_of(cnt);
    good = (kind != TYP_BAD);
    desc.kind = kind;
    desc.fua  = fua;
    desc.lba  = lba;
    desc.len  = len;
    desc.cont = good && have_prev_q && (lba == prev_end_q);
  end

  assign track_upd = hit && good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_end_q  <= '0;
      have_prev_q <= 1'b0;
    end else if (track_upd) begin
      prev_end_q  <= end_of(lba, len);
      have_prev_q <= 1'b1;
    end
  end

endmodule

// File: rtl/stor_cmd_fifo.sv
module stor_cmd_fifo
  import stor_cmd_pkg::*;
#(
  parameter int DEPTH = 32
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  cmd_desc_t                 din,
  input  logic                      pop,
  output cmd_desc_t                 dout,
  output logic                      empty,
  output logic                      full,
  output logic [$clog2(DEPTH):0]    count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W_F = PTR_W + 1;

  cmd_desc_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W_F-1:0] count_q;
  logic             do_push, do_pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W_F'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr_q];
  assign count   = count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/stor_cmd_decq.sv
module stor_cmd_decq
  import stor_cmd_pkg::*;
#(
  parameter int Q_DEPTH = 32
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  output logic                frm_ready,
  input  logic [31:0]         frm_data,
  output logic                q_valid,
  input  logic                q_pop,
  output logic [1:0]          q_type,
  output logic                q_fua,
  output logic                q_cont,
  output logic [47:0]         q_lba,
  output logic [16:0]         q_len
);

  localparam int QC_W = $clog2(Q_DEPTH) + 1;

  logic               accept_w;
  logic               push_w;
  logic [7:0]         op_w;
  logic               fua_w;
  logic [CNT_W-1:0]   cnt_w;
  logic [LBA_W-1:0]   lba_w;
  cmd_desc_t          new_desc_w;
  cmd_desc_t          head_w;
  logic               track_upd_w;
  logic               q_empty_w;
  logic               q_full_w;
  logic [QC_W-1:0]    q_count_w;

  assign frm_ready = !q_full_w;
  assign accept_w  = frm_valid && frm_ready;

  stor_cmd_frame_asm u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept_w),
    .data       (frm_data),
    .frame_done (push_w),
    .op         (op_w),
    .fua        (fua_w),
    .cnt        (cnt_w),
    .lba        (lba_w)
  );

  stor_cmd_classify u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (push_w),
    .op        (op_w),
    .fua       (fua_w),
    .cnt       (cnt_w),
    .lba       (lba_w),
    .desc      (new_desc_w),
    .track_upd (track_upd_w)
  );

  stor_cmd_fifo #(.DEPTH(Q_DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_w),
    .din   (new_desc_w),
    .pop   (q_pop),
    .dout  (head_w),
    .empty (q_empty_w),
    .full  (q_full_w),
    .count (q_count_w)
  );

  assign q_valid = !q_empty_w;
  assign q_type  = head_w.kind;
  assign q_fua   = head_w.fua;
  assign q_cont  = head_w.cont;
  assign q_lba   = head_w.lba;
  assign q_len   = head_w.len;

endmodule

// File: rtl/stor_cmd_decq_chk.sv
module stor_cmd_decq_chk #(
  parameter int QC_W = 6
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            full,
  input  logic            track_upd,
  input  logic [1:0]      new_kind,
  input  logic            new_cont,
  input  logic [16:0]     new_len,
  input  logic            q_valid,
  input  logic            q_pop,
  input  logic [47:0]     q_lba,
  input  logic [QC_W-1:0] count
);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_q | push;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8

  AST_FIRST_RANDOM: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !seen_q) |-> !new_cont); // R5

  AST_BAD_OP_RANDOM: assert property (@(posedge clk) disable iff (!rst_n)
    (push && new_kind == 2'b11) |-> (!new_cont && !track_upd)); // R6

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (new_len != '0)); // R2

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_pop) |=> (q_valid && $stable(q_lba))); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && !q_valid && !push) |=> (count == '0)); // R9

endmodule

bind stor_cmd_decq stor_cmd_decq_chk #(.QC_W(QC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push      (push_w),
  .full      (q_full_w),
  .track_upd (track_upd_w),
  .new_kind  (new_desc_w.kind),
  .new_cont  (new_desc_w.cont),
  .new_len   (new_desc_w.len),
  .q_valid   (q_valid),
  .q_pop     (q_pop),
  .q_lba     (q_lba),
  .count     (q_count_w)
);

// File: tb/test_stor_cmd_decq.sv
module test_stor_cmd_decq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [7:0]  op;
    logic        fua;
    logic [15:0] cnt;
    logic [47:0] lba;
    logic [1:0]  etype;
    logic        econt;
    logic [16:0] elen;
  } vec_t;

  // Walk: first random, follow-on, zero count, invalid in the middle,
  // jump, wrap at the top of the LBA space, overlap.
  localparam vec_t VECS [NVEC] = '{
    '{8'h20, 1'b0, 16'd8,  48'd100,            2'b01, 1'b0, 17'd8},
    '{8'h30, 1'b1, 16'd16, 48'd108,            2'b10, 1'b1, 17'd16},
    '{8'h20, 1'b0, 16'd0,  48'd124,            2'b01, 1'b1, 17'd65536},
    '{8'h20, 1'b0, 16'd4,  48'd65660,          2'b01, 1'b1, 17'd4},
    '{8'h7F, 1'b1, 16'd4,  48'd65664,          2'b11, 1'b0, 17'd4},
    '{8'h30, 1'b0, 16'd1,  48'd65664,          2'b10, 1'b1, 17'd1},
    '{8'h30, 1'b0, 16'd2,  48'd5000,           2'b10, 1'b0, 17'd2},
    '{8'h20, 1'b0, 16'd2,  48'hFFFF_FFFF_FFFE, 2'b01, 1'b0, 17'd2},
    '{8'h30, 1'b1, 16'd3,  48'd0,              2'b10, 1'b1, 17'd3},
    '{8'h20, 1'b0, 16'd1,  48'd2,              2'b01, 1'b0, 17'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [31:0] frm_data = '0;
  logic        q_valid;
  logic        q_pop = 1'b0;
  logic [1:0]  q_type;
  logic        q_fua;
  logic        q_cont;
  logic [47:0] q_lba;
  logic [16:0] q_len;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  stor_cmd_decq i_stor_cmd_decq (
    .clk, .rst_n, .frm_valid, .frm_ready, .frm_data,
    .q_valid, .q_pop, .q_type, .q_fua, .q_cont, .q_lba, .q_len
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] d);
    frm_valid = 1'b1;
    frm_data  = d;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] op, input logic fua,
                            input logic [15:0] cnt, input logic [47:0] lba);
    send_word({cnt, 7'd0, fua, op});
    send_word(lba[31:0]);
    send_word({16'h0, lba[47:32]});
  endtask

  task automatic pop_chk(input string tag, input logic [1:0] et, input logic ec,
                         input logic [47:0] el, input logic [16:0] en,
                         input logic ef);
    chk(q_valid == 1'b1, {tag, " R7 head valid"}, 64'(q_valid), 64'd1);
    chk(q_type == et, {tag, " R1 R6 type"}, 64'(q_type), 64'(et));
    chk(q_cont == ec, {tag, " R4 cont"}, 64'(q_cont), 64'(ec));
    chk(q_lba == el, {tag, " R2 lba"}, 64'(q_lba), 64'(el));
    chk(q_len == en, {tag, " R2 len"}, 64'(q_len), 64'(en));
    chk(q_fua == ef, {tag, " R3 fua"}, 64'(q_fua), 64'(ef));
    q_pop = 1'b1;
    @(negedge clk);
    q_pop = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R10: reset state
    chk(q_valid == 1'b0, "R10 queue empty after reset", 64'(q_valid), 64'd0);
    chk(frm_ready == 1'b1, "R10 ready after reset", 64'(frm_ready), 64'd1);

    // Vector table: queue all, then drain in order (R1..R7)
    for (int i = 0; i < NVEC; i++)
      send_frame(VECS[i].op, VECS[i].fua, VECS[i].cnt, VECS[i].lba);
    for (int i = 0; i < NVEC; i++)
      pop_chk($sformatf("vec%0d", i), VECS[i].etype, VECS[i].econt,
              VECS[i].lba, VECS[i].elen, VECS[i].fua);
    chk(q_valid == 1'b0, "R7 queue drained", 64'(q_valid), 64'd0);

    // R9: pop on empty queue has no effect
    q_pop = 1'b1;
    repeat (2) @(negedge clk);
    q_pop = 1'b0;
    chk(q_valid == 1'b0, "R9 empty pop keeps empty", 64'(q_valid), 64'd0);
    send_frame(8'h30, 1'b0, 16'd5, 48'd3);   // previous end was 3
    pop_chk("R9 after empty pop", 2'b10, 1'b1, 48'd3, 17'd5, 1'b0);
    chk(q_valid == 1'b0, "R9 single entry removed", 64'(q_valid), 64'd0);

    // R10 and R5: reset mid-frame; tracker and frame index restart
    send_frame(8'h20, 1'b0, 16'd2, 48'd40);
    send_word({16'd9, 7'd0, 1'b1, 8'h30});   // word 0 only
    do_reset();
    chk(q_valid == 1'b0, "R10 reset clears queue", 64'(q_valid), 64'd0);
    send_frame(8'h20, 1'b1, 16'd7, 48'd42);  // would follow on without reset
    pop_chk("R5 R10 first after reset", 2'b01, 1'b0, 48'd42, 17'd7, 1'b1);

    // R8: fill queue, hold a 33rd frame, no loss
    do_reset();
    for (int i = 0; i < 32; i++) send_frame(8'h30, 1'b0, 16'd1, 48'(i));
    chk(frm_ready == 1'b0, "R8 ready low when full", 64'(frm_ready), 64'd0);
    frm_valid = 1'b1;
    frm_data  = {16'd1, 7'd0, 1'b0, 8'h30};
    repeat (3) @(negedge clk);
    chk(frm_ready == 1'b0, "R8 stalled while full", 64'(frm_ready), 64'd0);
    chk(q_lba == 48'd0, "R7 head stable under stall", q_lba, 64'd0);
    pop_chk("R8 first of full", 2'b10, 1'b0, 48'd0, 17'd1, 1'b0);
    send_word({16'd1, 7'd0, 1'b0, 8'h30});
    send_word(32'd32);
    send_word(32'd0);
    for (int i = 1; i <= 32; i++)
      pop_chk($sformatf("R8 drain %0d", i), 2'b10, 1'b1, 48'(i), 17'd1, 1'b0);
    chk(q_valid == 1'b0, "R8 all drained", 64'(q_valid), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule